// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block connects a clocked system to an external asynchronous static RAM of 65,536 words of 16 bits. The system side uses a simple request port with a valid strobe, a write flag, a 16-bit word address, 16-bit write data and a two-bit byte mask. The block returns a ready flag, read data and a one-clock read-valid pulse. On the memory side it drives the address and five active-low strobes: chip select, output enable, write enable, and one enable per byte lane. It also drives a data bus that is split into an outgoing word, a driver enable and an incoming word.

Every memory-side output comes from a register. The read-sample delay and the write-strobe width are counted in system clocks and set by the parameters `WAIT_RD` and `WAIT_WR`. Both must be at least 1. The defaults give at least 20 ns per phase at 100 MHz, which covers a 10 ns access time, a 7 ns write pulse and a 5 ns data setup. The block drives the data bus only while write enable is low, starting one clock after it falls, and for one clock after it rises. It never enables the memory's outputs while its own driver is on or was on in the previous clock.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied and after it is released, all five strobes are high, the data driver is off, `req_ready` is 1 and `rd_valid` is 0.
- R2: After a read is accepted, chip select and output enable stay low for exactly `WAIT_RD` clocks and write enable stays high. The upper byte enable is low when mask bit 1 is set, and the lower byte enable is low when mask bit 0 is set.
- R3: A read captures `sram_dq_in` at the last clock edge of its strobe window. `rd_valid` is high for exactly one clock, in the same clock in which `req_ready` returns. Byte lanes whose mask bit is clear read back as zero.
- R4: After a write is accepted, chip select and write enable stay low for exactly `WAIT_WR`+1 clocks. Output enable stays high for the whole write.
- R5: The data driver is off in the first clock of the write strobe. It is on for the remaining `WAIT_WR` clocks of the strobe and for one more clock after write enable rises, so it is on for `WAIT_WR`+1 clocks in total. `sram_dq_out` carries the write data while the driver is on.
- R6: Output enable is never low in a clock in which the data driver is on, or in the clock that follows one. A write followed at once by a read therefore has at least one idle bus clock between them.
- R7: `req_ready` falls in the clock after acceptance and stays low until the operation finishes: `WAIT_RD` clocks for a read and `WAIT_WR`+2 clocks for a write. Requests that arrive while it is low start no memory cycle and change no memory contents.
- R8: A write asserts only the byte enables selected by its mask, so only those bytes change in the memory. Mask bit 1 selects data bits 15..8 and mask bit 0 selects bits 7..0.
- R9: A request whose mask is zero asserts no strobe, holds `req_ready` low for one clock and gives no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask: bit 1 = bits 15..8, bit 0 = bits 7..0 |
| req_ready | output | 1 | Ready to accept a request |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is new |
| sram_addr | output | 16 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Driver enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data returned by the memory |

## Verification
The main function is tested with a sequence of writes, each followed at once by a read of the same address. The writes use full, upper-only and lower-only masks. These sequences show whether the byte enables really limit which bytes change, and whether masked read lanes come back as zero. A behavioural memory in the bench drives a fixed filler pattern on disabled lanes, so a capture that ignores the mask gives a wrong value. Monitors on every clock check strobe widths, the turnaround gap after the data driver and the byte enables during writes. Directed cases cover a zero mask, requests made while busy, and a read of an address that was never written.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the static RAM sequencer.
// Assumes: one state encoding is used by the sequencer only.
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_START,
        ST_WR_DATA,
        ST_WR_END,
        ST_NOP
    } seq_state_t;
endpackage

// File: rtl/sram_ctrl_wait_cnt.sv
// Loadable down-counter that times the read and write phases.
// Assumes: the load value is the phase length minus one; expired is high at zero.
module sram_ctrl_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Expired flag for the sequencer.
    always_comb expired = (cnt == '0);

    // R2 R4: phase timing relies on a steady decrement
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sram_ctrl_rdcap.sv
// Read-data capture register with per-lane masking and a one-clock valid pulse.
// Assumes: cap_en is high for a single clock per read.
module sram_ctrl_rdcap #(
    parameter int DATA_W = 16,
    localparam int NB = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [NB-1:0]     cap_be,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Valid pulse follows the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= cap_en;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        // Capture one byte lane; a lane outside the mask reads as zero.
        always_ff @(posedge clk) begin
            if (!rst_n)      rd_data[g*8 +: 8] <= '0;
            else if (cap_en) rd_data[g*8 +: 8] <= cap_be[g] ? dq_in[g*8 +: 8] : 8'h00;
        end
    end

    // R3
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctrl_seq.sv
// Sequencer: accepts requests and drives the registered memory strobes and data driver.
// Assumes: WAIT_RD, WAIT_WR >= 1; strobes are active low; be mask bit set = lane enabled.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int WAIT_RD = 2,
    parameter int WAIT_WR = 2,
    parameter int CNT_W   = 2,
    localparam int NB = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NB-1:0]     req_be,
    input  logic              cnt_expired,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              cap_en,
    output logic [NB-1:0]     cap_be,
    output logic              req_ready,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [NB-1:0]     be_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    seq_state_t    state;
    logic [NB-1:0] be_q;
    logic          accept;

    // Acceptance of a new request in idle.
    always_comb accept = (state == ST_IDLE) && req_valid;

    // Counter load for the read window and for the data-driven write window.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept && !req_write && req_be != '0) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(WAIT_RD - 1);
        end else if (state == ST_WR_START) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(WAIT_WR - 1);
        end
    end

    // Capture strobe at the last read clock.
    always_comb begin
        cap_en = (state == ST_RD) && cnt_expired;
        cap_be = be_q;
    end

    // State machine with registered memory-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            be_n      <= '1;
            dq_oe     <= 1'b0;
            be_q      <= '0;
            sram_addr <= '0;
            dq_out    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    req_ready <= 1'b0;
                    sram_addr <= req_addr;
                    dq_out    <= req_wdata;
                    be_q      <= req_be;
                    if (req_be == '0) begin
                        state <= ST_NOP;
                    end else if (req_write) begin
                        state <= ST_WR_START;
                        cs_n  <= 1'b0;
                        we_n  <= 1'b0;
                        be_n  <= ~req_be;
                    end else begin
                        state <= ST_RD;
                        cs_n  <= 1'b0;
                        oe_n  <= 1'b0;
                        be_n  <= ~req_be;
                    end
                end
                ST_RD: if (cnt_expired) begin
                    state     <= ST_IDLE;
                    req_ready <= 1'b1;
                    cs_n      <= 1'b1;
                    oe_n      <= 1'b1;
                    be_n      <= '1;
                end
                ST_WR_START: begin
                    state <= ST_WR_DATA;
                    dq_oe <= 1'b1;
                end
                ST_WR_DATA: if (cnt_expired) begin
                    state <= ST_WR_END;
                    cs_n  <= 1'b1;
                    we_n  <= 1'b1;
                    be_n  <= '1;
                end
                ST_WR_END: begin
                    state     <= ST_IDLE;
                    dq_oe     <= 1'b0;
                    req_ready <= 1'b1;
                end
                ST_NOP: begin
                    state     <= ST_IDLE;
                    req_ready <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && !$past(dq_oe)));
    // R5
    data_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($past(dq_oe) && dq_oe));
    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);
    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_be == '0) |=> (cs_n && we_n && oe_n));
endmodule

// File: rtl/sram_ctrl.sv
// Top: synchronous request port to an asynchronous 16-bit static RAM.
// Assumes: WAIT_RD and WAIT_WR are at least 1; two byte lanes.
module sram_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int WAIT_RD = 2,
    parameter int WAIT_WR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int NB       = DATA_W / 8;
    localparam int WAIT_MAX = (WAIT_RD > WAIT_WR) ? WAIT_RD : WAIT_WR;
    localparam int CNT_W    = (WAIT_MAX < 2) ? 1 : $clog2(WAIT_MAX);

    logic             cnt_load, cnt_expired, cap_en;
    logic [CNT_W-1:0] cnt_val;
    logic [NB-1:0]    cap_be, be_n;

    sram_ctrl_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_RD(WAIT_RD),
        .WAIT_WR(WAIT_WR), .CNT_W(CNT_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cnt_expired(cnt_expired), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .cap_en(cap_en), .cap_be(cap_be), .req_ready(req_ready),
        .sram_addr(sram_addr), .cs_n(sram_cs_n), .oe_n(sram_oe_n),
        .we_n(sram_we_n), .be_n(be_n), .dq_out(sram_dq_out), .dq_oe(sram_dq_oe)
    );

    sram_ctrl_wait_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .expired(cnt_expired)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_be(cap_be),
        .dq_in(sram_dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Byte lane enables to the memory pins.
    always_comb begin
        sram_ub_n = be_n[NB-1];
        sram_lb_n = be_n[0];
    end

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && !sram_dq_oe));
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb_top;
    localparam int WRD = 2;
    localparam int WWR = 2;
    localparam int NV  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data, sram_addr, sram_dq_out, sram_dq_in;
    logic        sram_cs_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    sram_ctrl #(.WAIT_RD(WRD), .WAIT_WR(WWR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Behavioural memory (low 8 address bits); disabled lanes return filler A5.
    logic [15:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    always_comb begin
        sram_dq_in = 16'hA5A5;
        if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
            if (!sram_ub_n) sram_dq_in[15:8] = mem[sram_addr[7:0]][15:8];
            if (!sram_lb_n) sram_dq_in[7:0]  = mem[sram_addr[7:0]][7:0];
        end
    end

    // Monitors sampled at the falling edge.
    int oe_low, we_low, dqoe_on, cs_fall, rdv_cnt, turn_viol, first_drive, be_viol;
    logic prev_dqoe = 1'b0, prev_cs = 1'b1, prev_we = 1'b1;
    logic [1:0] cur_be = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_cs_n && !sram_we_n && sram_dq_oe) begin
                if (!sram_ub_n) mem[sram_addr[7:0]][15:8] = sram_dq_out[15:8];
                if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  = sram_dq_out[7:0];
            end
            if (!sram_oe_n) oe_low++;
            if (!sram_we_n) we_low++;
            if (sram_dq_oe) dqoe_on++;
            if (!sram_cs_n && prev_cs) cs_fall++;
            if (rd_valid) rdv_cnt++;
            if (!sram_oe_n && (sram_dq_oe || prev_dqoe)) turn_viol++;
            if (!sram_we_n && prev_we && sram_dq_oe) first_drive++;
            if (!sram_we_n && {sram_ub_n, sram_lb_n} != ~cur_be) be_viol++;
        end
        prev_dqoe = sram_dq_oe;
        prev_cs   = sram_cs_n;
        prev_we   = sram_we_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        oe_low = 0; we_low = 0; dqoe_on = 0; cs_fall = 0; rdv_cnt = 0;
        first_drive = 0;
    endtask

    int busy;
    // Issue one request and wait until ready returns; busy = clocks with ready low.
    task automatic do_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        clr_mon();
        cur_be = be;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready && busy < 50) begin
            busy++;
            @(negedge clk);
        end
    endtask

    // wr, addr, data, mask, expected read value
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 16'h0010, 16'h1234, 2'b11, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1234},
        {1'b1, 16'h0010, 16'hABCD, 2'b10, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b11, 16'hAB34},
        {1'b1, 16'h0010, 16'hEF99, 2'b01, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b01, 16'h0099},
        {1'b0, 16'h0010, 16'h0000, 2'b10, 16'hAB00},
        {1'b1, 16'h0020, 16'h5A5A, 2'b11, 16'h0000},
        {1'b0, 16'h0020, 16'h0000, 2'b11, 16'h5A5A},
        {1'b0, 16'h0021, 16'h0000, 2'b11, 16'h0000}
    };

    initial begin
        turn_viol = 0; be_viol = 0;
        clr_mon();
        repeat (3) @(negedge clk);
        // R1: outputs held during reset
        chk("R1 strobes in reset", {sram_cs_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}, 5'h1F);
        chk("R1 ready/driver/valid in reset", {req_ready, sram_dq_oe, rd_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready}, 5'b11101);

        for (int i = 0; i < NV; i++) begin
            logic wr; logic [15:0] a, d, e; logic [1:0] be;
            {wr, a, d, be, e} = VEC[i];
            do_op(wr, a, d, be);
            if (wr) begin
                chk("R4 write strobe clocks", we_low, WWR + 1);
                chk("R4 no output enable in write", oe_low, 0);
                chk("R5 driver clocks", dqoe_on, WWR + 1);
                chk("R5 driver off in first strobe clock", first_drive, 0);
                chk("R7 write busy clocks", busy, WWR + 2);
            end else begin
                chk("R2 read strobe clocks", oe_low, WRD);
                chk("R2 no write strobe in read", we_low, 0);
                chk("R7 read busy clocks", busy, WRD);
                chk("R3 valid with ready", rd_valid, 1'b1);
                chk("R3 R8 read data", rd_data, e);
                @(negedge clk);
                chk("R3 valid one clock", rd_valid, 1'b0);
            end
        end

        // R9: zero mask write then read of untouched word
        do_op(1'b1, 16'h0010, 16'h0000, 2'b00);
        chk("R9 no chip select", cs_fall, 0);
        chk("R9 busy one clock", busy, 1);
        do_op(1'b0, 16'h0010, 16'h0000, 2'b00);
        chk("R9 no chip select on read", cs_fall, 0);
        @(negedge clk);
        chk("R9 no valid pulse", rdv_cnt, 0);
        do_op(1'b0, 16'h0010, 16'h0000, 2'b11);
        chk("R9 word unchanged", rd_data, 16'hAB99);

        // R7: request made while busy is ignored
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        clr_mon();
        cur_be = 2'b11;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0040; req_wdata = 16'h1111; req_be = 2'b11;
        @(negedge clk);
        req_addr = 16'h0030; req_wdata = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        chk("R7 one memory cycle", cs_fall, 1);
        do_op(1'b0, 16'h0030, 16'h0000, 2'b11);
        chk("R7 ignored write left word", rd_data, 16'h0000);
        do_op(1'b0, 16'h0040, 16'h0000, 2'b11);
        chk("R7 accepted write stored", rd_data, 16'h1111);

        chk("R6 turnaround violations", turn_viol, 0);
        chk("R8 byte enable violations", be_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule